// File: doc/BRIEF.md
# Trimmed Seconds Timebase

This block sits between a low-frequency oscillator and a BCD time-of-day counter. It divides an oscillator enable that runs at a nominal 32768 Hz into two pulse outputs. One is a seconds pulse. The other is a hundredths pulse, and each second always holds exactly one hundred of them. The calendar logic downstream counts these pulses. It returns a strobe at every minute rollover.

Slow or fast crystals are corrected digitally over a repeating cycle of 64 minutes. A 5-bit magnitude N selects how many minutes carry a correction: the first 2N minutes of the cycle. In each of those minutes, one second is made shorter or longer. The sign input selects the direction. A stop input freezes the whole chain. A clear input restarts it, and the surrounding logic asserts clear when new time values are loaded. A test output gives a 512 Hz square wave. Its frequency does not depend on the trim setting, so the raw oscillator can be measured on a bench.

Top module: `timebase_trim`

## Requirements
- R1: With magnitude 0, a seconds pulse occurs once every 32768 counted oscillator ticks. A tick counts only when `osc_tick` is 1 and `halt` is 0.
- R2: Exactly 100 hundredths pulses occur in every second, whatever its length. The hundredth of them lands in the same cycle as the seconds pulse.
- R3: With `cal_sign` = 1, a minute strobe inside the correction window makes the next second 256 ticks shorter (32512 ticks).
- R4: With `cal_sign` = 0, such a strobe makes the next second 128 ticks longer (32896 ticks). Later seconds return to 32768 ticks.
- R5: The minute index counts strobes modulo 64, starting at 0. A strobe arms a correction only while the index, read before that strobe advances it, is below 2 × `cal_mag`. After index 63 the index wraps to 0, and the window opens again.
- R6: While `halt` is 1, no tick is counted and no pulse is emitted. When `halt` returns to 0, the second resumes where it stopped.
- R7: Reset and a `div_clear` pulse both zero the tick position, the hundredths phase, the minute index and any armed correction. All outputs are 0 after reset. The first second after a clear is exactly one second long.
- R8: While `ftest_en` is 1 and `halt` is 0, `ftest_out` toggles every 32 counted ticks (512 Hz), starting low after a clear. The trim setting has no effect on it. When `ftest_en` is 0 or `halt` is 1, `ftest_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| cal_sign | input | 1 | 1 shortens corrected seconds, 0 lengthens them |
| cal_mag | input | 5 | Correction magnitude N; window is the first 2N minutes |
| halt | input | 1 | Freezes the divider and the test wave |
| ftest_en | input | 1 | Enables the 512 Hz test output |
| div_clear | input | 1 | Restarts divider, phase and minute cycle |
| minute_strobe | input | 1 | Pulse at each minute rollover of the calendar |
| hund_tick | output | 1 | One-cycle hundredths pulse |
| sec_tick | output | 1 | One-cycle seconds pulse |
| ftest_out | output | 1 | 512 Hz test square wave |

## Verification
The hardest case to reach is the closed-then-reopened correction window. The index has to move past 2N and then wrap from 63 back to 0. A wrong window compare, or a wrong wrap, only shows as one wrong second length minutes later. The stimulus reaches that state by firing bursts of minute strobes within a single second. A second that starts after a burst of out-of-window strobes must stay nominal. The strobe after the wrap must arm a shortened second again. The bench also runs with a scaled oscillator rate, which keeps whole seconds short enough to measure exactly.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  typedef enum logic [1:0] {
    SEC_NOMINAL = 2'd0,
    SEC_FAST    = 2'd1,
    SEC_SLOW    = 2'd2
  } sec_kind_t;
endpackage

// File: rtl/trim_scheduler.sv
module trim_scheduler
  import timebase_pkg::*;
#(
  parameter int CYCLE_MIN = 64,
  parameter int MAG_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             minute_strobe,
  input  logic             sec_start,
  input  logic             cal_sign,
  input  logic [MAG_W-1:0] cal_mag,
  output sec_kind_t        kind
);
  localparam int IDX_W = $clog2(CYCLE_MIN);
  localparam int CMP_W = ((IDX_W > MAG_W + 1) ? IDX_W : MAG_W + 1) + 1;

  logic [IDX_W-1:0] min_idx, min_idx_d;
  logic             pending, pending_d;
  sec_kind_t        kind_q, kind_d;
  logic             in_window, armed;

  always_comb begin
    in_window = CMP_W'(min_idx) < CMP_W'({cal_mag, 1'b0});
    armed     = pending | (minute_strobe & in_window);
    min_idx_d = min_idx;
    pending_d = pending;
    kind_d    = kind_q;
    if (clr) begin
      min_idx_d = '0;
      pending_d = 1'b0;
      kind_d    = SEC_NOMINAL;
    end else begin
      if (minute_strobe)
        min_idx_d = (min_idx == IDX_W'(CYCLE_MIN - 1)) ? '0 : min_idx + 1'b1;
      if (sec_start) begin
        pending_d = 1'b0;
        kind_d    = armed ? (cal_sign ? SEC_FAST : SEC_SLOW) : SEC_NOMINAL;
      end else begin
        pending_d = armed;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_idx <= '0;
      pending <= 1'b0;
      kind_q  <= SEC_NOMINAL;
    end else begin
      min_idx <= min_idx_d;
      pending <= pending_d;
      kind_q  <= kind_d;
    end
  end

  assign kind = kind_q;

  // R5: a correction is only ever armed by a minute strobe
  assert_pending_from_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(minute_strobe));

  // R3: the length class of a second changes only at a boundary or a clear
  assert_kind_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(kind_q) |-> $past(sec_start || clr));
endmodule

// File: rtl/second_divider.sv
module second_divider
  import timebase_pkg::*;
#(
  parameter int OSC_HZ    = 32768,
  parameter int HUND      = 100,
  parameter int FAST_TRIM = 256,
  parameter int SLOW_TRIM = 128
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      adv,
  input  sec_kind_t kind,
  output logic      sec_start,
  output logic      sec_tick,
  output logic      hund_tick
);
  localparam int LEN_NOM  = OSC_HZ;
  localparam int LEN_FAST = OSC_HZ - FAST_TRIM;
  localparam int LEN_SLOW = OSC_HZ + SLOW_TRIM;
  localparam int CNT_W    = $clog2(LEN_SLOW + 1);
  localparam int ACC_W    = $clog2(LEN_SLOW + HUND + 1);

  logic [CNT_W-1:0] cnt, cnt_d, len;
  logic [ACC_W-1:0] acc, acc_d, acc_sum;
  logic             last, hit, sec_d, hund_d, sec_q, hund_q;

  always_comb begin
    unique case (kind)
      SEC_FAST: len = CNT_W'(LEN_FAST);
      SEC_SLOW: len = CNT_W'(LEN_SLOW);
      default:  len = CNT_W'(LEN_NOM);
    endcase
    last      = (cnt == len - CNT_W'(1));
    acc_sum   = acc + ACC_W'(HUND);
    hit       = (acc_sum >= ACC_W'(len));
    sec_start = adv & last & ~clr;
    cnt_d     = cnt;
    acc_d     = acc;
    sec_d     = 1'b0;
    hund_d    = 1'b0;
    if (clr) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (adv) begin
      cnt_d  = last ? '0 : cnt + CNT_W'(1);
      acc_d  = hit ? acc_sum - ACC_W'(len) : acc_sum;
      sec_d  = last;
      hund_d = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      sec_q  <= 1'b0;
      hund_q <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      acc    <= acc_d;
      sec_q  <= sec_d;
      hund_q <= hund_d;
    end
  end

  assign sec_tick  = sec_q;
  assign hund_tick = hund_q;

  // R1: the tick position never leaves the current second
  assert_cnt_in_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);

  // R2: the closing hundredth coincides with every seconds pulse
  assert_sec_with_hund_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q |-> hund_q);

  // R6: a cycle without a counted tick produces no pulse
  assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> (!sec_q && !hund_q));
endmodule

// File: rtl/test_wave.sv
module test_wave #(
  parameter int HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic en,
  output logic wave
);
  localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PH_W-1:0] ph, ph_d;
  logic            wave_q, wave_d, wrap;

  always_comb begin
    wrap   = (ph == PH_W'(HALF - 1));
    ph_d   = ph;
    wave_d = wave_q;
    if (clr) begin
      ph_d   = '0;
      wave_d = 1'b0;
    end else if (adv) begin
      ph_d   = wrap ? '0 : ph + PH_W'(1);
      wave_d = wave_q ^ wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      wave_q <= 1'b0;
    end else begin
      ph     <= ph_d;
      wave_q <= wave_d;
    end
  end

  assign wave = wave_q & en;

  // R8: the square wave moves only on a counted tick or a clear
  assert_wave_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave_q) |-> $past(adv || clr));
endmodule

// File: rtl/timebase_trim.sv
module timebase_trim
  import timebase_pkg::*;
#(
  parameter int OSC_HZ    = 32768,
  parameter int HUND      = 100,
  parameter int FAST_TRIM = 256,
  parameter int SLOW_TRIM = 128,
  parameter int CYCLE_MIN = 64,
  parameter int TEST_HALF = 32,
  parameter int MAG_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             cal_sign,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             halt,
  input  logic             ftest_en,
  input  logic             div_clear,
  input  logic             minute_strobe,
  output logic             hund_tick,
  output logic             sec_tick,
  output logic             ftest_out
);
  logic [1:0] rst_pipe;
  logic       rst_s_n, adv, sec_start;
  sec_kind_t  kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];
  assign adv     = osc_tick & ~halt;

  trim_scheduler #(.CYCLE_MIN(CYCLE_MIN), .MAG_W(MAG_W)) u_sched (
    .clk(clk), .rst_n(rst_s_n), .clr(div_clear), .minute_strobe(minute_strobe),
    .sec_start(sec_start), .cal_sign(cal_sign), .cal_mag(cal_mag), .kind(kind)
  );

  second_divider #(.OSC_HZ(OSC_HZ), .HUND(HUND), .FAST_TRIM(FAST_TRIM),
                   .SLOW_TRIM(SLOW_TRIM)) u_div (
    .clk(clk), .rst_n(rst_s_n), .clr(div_clear), .adv(adv), .kind(kind),
    .sec_start(sec_start), .sec_tick(sec_tick), .hund_tick(hund_tick)
  );

  test_wave #(.HALF(TEST_HALF)) u_wave (
    .clk(clk), .rst_n(rst_s_n), .clr(div_clear), .adv(adv),
    .en(ftest_en & ~halt), .wave(ftest_out)
  );
endmodule

// File: tb/tb_timebase_trim.sv
`timescale 1ns/1ps
module tb_timebase_trim;
  localparam int OSC  = 2048;
  localparam int FT   = 16;
  localparam int ST   = 8;
  localparam int HUND = 100;
  localparam int HALF = 32;
  localparam int LNOM = OSC;
  localparam int LFST = OSC - FT;
  localparam int LSLW = OSC + ST;

  logic clk = 1'b0;
  logic rst_n, osc_tick, cal_sign, halt, ftest_en, div_clear, minute_strobe;
  logic [4:0] cal_mag;
  logic hund_tick, sec_tick, ftest_out;

  always #2.5 clk = ~clk;

  timebase_trim #(.OSC_HZ(OSC), .HUND(HUND), .FAST_TRIM(FT), .SLOW_TRIM(ST),
                  .CYCLE_MIN(64), .TEST_HALF(HALF), .MAG_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_sign(cal_sign),
    .cal_mag(cal_mag), .halt(halt), .ftest_en(ftest_en), .div_clear(div_clear),
    .minute_strobe(minute_strobe), .hund_tick(hund_tick), .sec_tick(sec_tick),
    .ftest_out(ftest_out)
  );

  typedef struct { int len; string tag; } exp_t;
  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0;
  int tick_cnt = 0, hcnt = 0, wave_cnt = 0, halt_leak = 0;
  bit wave_chk = 0, mon_on = 0, done = 0;
  logic wave_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic push(input int len, input string tag);
    exp_t e;
    e.len = len; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic pulse_clear();
    @(negedge clk) div_clear = 1'b1;
    @(negedge clk) div_clear = 1'b0;
  endtask

  task automatic pulse_strobe();
    @(negedge clk) minute_strobe = 1'b1;
    @(negedge clk) minute_strobe = 1'b0;
  endtask

  task automatic wait_sec();
    do @(negedge clk); while (!sec_tick);
  endtask

  // monitor: samples 1 ns after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (mon_on) begin
      if (div_clear) begin
        tick_cnt = 0; hcnt = 0; wave_cnt = 0;
      end else if (osc_tick && !halt) begin
        tick_cnt++; wave_cnt++;
      end
      if (hund_tick) hcnt++;
      if (halt && (sec_tick || hund_tick)) halt_leak++;
      if (sec_tick) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(tick_cnt == e.len, e.tag, tick_cnt, e.len);
          check(hcnt == HUND, "R2", hcnt, HUND);
        end
        tick_cnt = 0; hcnt = 0;
      end
      if (ftest_out !== wave_prev) begin
        if (wave_chk) check(wave_cnt == HALF, "R8", wave_cnt, HALF);
        wave_cnt = 0;
      end
      wave_prev = ftest_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; osc_tick = 1'b0; cal_sign = 1'b0; cal_mag = 5'd0; halt = 1'b0;
    ftest_en = 1'b0; div_clear = 1'b0; minute_strobe = 1'b0;
    repeat (5) @(negedge clk);
    // R7: reset state
    check(sec_tick == 1'b0, "R7", sec_tick, 0);
    check(hund_tick == 1'b0, "R7", hund_tick, 0);
    check(ftest_out == 1'b0, "R7", ftest_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1; osc_tick = 1'b1;

    // R1: nominal seconds
    pulse_clear();
    push(LNOM, "R1"); push(LNOM, "R1");
    wait_sec(); wait_sec();

    // R3: shortened second after an in-window strobe
    cal_sign = 1'b1; cal_mag = 5'd1;
    pulse_clear(); pulse_strobe();
    push(LNOM, "R3"); push(LFST, "R3");
    wait_sec(); wait_sec();

    // R4: lengthened second, then back to nominal
    cal_sign = 1'b0; cal_mag = 5'd31;
    pulse_clear(); pulse_strobe();
    push(LNOM, "R4"); push(LSLW, "R4");
    wait_sec(); wait_sec();
    push(LNOM, "R4");
    wait_sec();

    // R5: window closes at index 2N and reopens after wrap
    cal_sign = 1'b1; cal_mag = 5'd1;
    pulse_clear(); pulse_strobe(); pulse_strobe();
    push(LNOM, "R5"); push(LFST, "R5");
    wait_sec(); wait_sec();
    for (int i = 0; i < 62; i++) pulse_strobe();
    push(LNOM, "R5");
    wait_sec();
    pulse_strobe();
    push(LNOM, "R5"); push(LFST, "R5");
    wait_sec(); wait_sec();

    // R6: halt freezes counting mid-second
    cal_mag = 5'd0; ftest_en = 1'b1;
    pulse_clear();
    push(LNOM, "R6");
    repeat (500) @(negedge clk);
    halt = 1'b1;
    repeat (80) @(negedge clk);
    check(ftest_out == 1'b0, "R8", ftest_out, 0);
    halt = 1'b0;
    wait_sec();
    check(halt_leak == 0, "R6", halt_leak, 0);
    ftest_en = 1'b0;

    // R7: clear mid-second, and clear resets the minute index
    repeat (700) @(negedge clk);
    cal_sign = 1'b1; cal_mag = 5'd1;
    for (int i = 0; i < 5; i++) pulse_strobe();
    pulse_clear(); pulse_strobe();
    push(LNOM, "R7"); push(LFST, "R7");
    wait_sec(); wait_sec();

    // R8: test wave unaffected by a shortened second
    cal_sign = 1'b1; cal_mag = 5'd1;
    @(negedge clk) begin div_clear = 1'b1; ftest_en = 1'b1; wave_chk = 1; end
    @(negedge clk) div_clear = 1'b0;
    pulse_strobe();
    push(LNOM, "R8"); push(LFST, "R8");
    wait_sec(); wait_sec();
    wave_chk = 0; ftest_en = 1'b0;
    repeat (100) @(negedge clk);
    check(ftest_out == 1'b0, "R8", ftest_out, 0);

    check(exp_q.size() == 0, "R1", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule